// File: doc/BRIEF.md
# Line-Buffered Bilinear Image Downscaler

This block shrinks an 8-bit grayscale frame to a smaller size. The output is built one line at a time. For every output line the block requests two source rows from an external pixel source, holds them in a local line buffer, computes the output line one pixel per cycle by bilinear interpolation, and hands the finished line to an output stream.

The three activities run as a pipeline over whole lines. Two input slots let the next pair of source rows arrive while the current line is computed. Two output slots let a finished line drain while the next one is computed. When both output slots are full, computation stops, and fetching stops one pair of slots later. Sizes and scale steps are supplied at the start of each frame. A start pulse launches the frame, and a flag marks the last output pixel.

Top module: `line_downscaler`

## Requirements
- R1: After reset, `busy`, `fetch_req`, `in_ready` and `out_valid` are all low.
- R2: A `start` pulse while idle captures all configuration inputs and raises `busy`. Later changes on the configuration inputs do not affect the frame. `busy` falls in the cycle after the last output pixel is accepted.
- R3: Each output line y causes exactly two fetch requests, in this order:
  - first row r0 = min(floor(y*step_y / 2^16), in_h-1);
  - then row r1 = min(r0+1, in_h-1).
  After each request the block accepts exactly in_w pixels, left to right, on cycles with `in_valid` and `in_ready` both high. `in_ready` is high in the cycle after a request.
- R4: Output pixel (x,y) is computed as follows.
  - Let sx = x*step_x and sy = y*step_y, with 16 fractional bits.
  - The weights are fx = sx[15:8] and fy = sy[15:8].
  - The value is V = ((a*(256-fx) + b*fx)*(256-fy) + (c*(256-fx) + d*fx)*fy + 32768) >> 16, saturated to 255.
  - a and b are pixels i0 and i1 of row r0; c and d are the same pixels of row r1.
- R5: The columns are i0 = min(floor(sx/2^16), in_w-1) and i1 = min(i0+1, in_w-1), so reads past the right edge repeat the last pixel.
- R6: Output pixels leave in raster order, out_w per line and out_h lines. `frame_done` is high exactly with the last pixel of the frame.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` stays unchanged.
- R8: With `out_ready` held low from the start of a frame that has at least four output lines, the block issues exactly 8 fetch requests and then waits.
- R9: A `start` pulse while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a frame (ignored while busy) |
| cfg_in_w | input | 12 | Source width, 1..64 |
| cfg_in_h | input | 12 | Source height |
| cfg_out_w | input | 12 | Output width, 1..64 |
| cfg_out_h | input | 12 | Output height |
| cfg_step_x | input | 24 | Horizontal source step, 16 fractional bits, at least 1.0 |
| cfg_step_y | input | 24 | Vertical source step, 16 fractional bits, at least 1.0 |
| fetch_req | output | 1 | One-cycle request for a source row |
| fetch_row | output | 12 | Row index of the request |
| in_valid | input | 1 | Source pixel valid |
| in_data | input | 8 | Source pixel |
| in_ready | output | 1 | Block accepts a source pixel |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Sink accepts output pixel |
| out_data | output | 8 | Output pixel |
| frame_done | output | 1 | Marks last output pixel of the frame |
| busy | output | 1 | Frame in progress |

## Verification
The hardest state to reach is the full stall. In that state both output slots hold finished lines, computation has stopped, and fetching has stopped behind it. Random backpressure almost never holds long enough to get there. The bench therefore keeps `out_ready` low from the start pulse for several hundred cycles, checks that the fetch count settles at exactly eight, and then releases the sink and checks every pixel. Edge clamping is reached with fractional steps whose last sample lands beyond the final source column and row. Widths of one and a frame of saturated pixels cover the arithmetic extremes.

// File: rtl/dsc_pkg.sv
package dsc_pkg;
  localparam int FRAC_W = 16;
  localparam int WT_W   = 8;
  localparam int PIX_W  = 8;

  typedef enum logic [1:0] {F_IDLE, F_REQ, F_RX} fetch_st_t;
  typedef enum logic {C_IDLE, C_RUN} comp_st_t;
endpackage

// File: rtl/dsc_fetch.sv
module dsc_fetch
  import dsc_pkg::*;
#(
  parameter int DIM_W  = 12,
  parameter int STEP_W = 24,
  parameter int AW     = 6
) (
  input  logic              clk,
  input  logic              rst_l,
  input  logic              restart,
  input  logic              run,
  input  logic [DIM_W-1:0]  cfg_in_w,
  input  logic [DIM_W-1:0]  cfg_in_h,
  input  logic [DIM_W-1:0]  cfg_out_h,
  input  logic [STEP_W-1:0] step_y,
  input  logic [1:0]        slot_full,
  output logic [1:0]        set_full,
  output logic              fetch_req,
  output logic [DIM_W-1:0]  fetch_row,
  input  logic              in_valid,
  input  logic [PIX_W-1:0]  in_data,
  output logic              in_ready,
  output logic              we,
  output logic [AW+1:0]     waddr,
  output logic [PIX_W-1:0]  wdata
);
  localparam int ACC_W = DIM_W + STEP_W;
  localparam int IW    = ACC_W - FRAC_W;

  fetch_st_t st_q, st_d;
  logic slot_q, slot_d, line_q, line_d;
  logic [DIM_W-1:0] x_q, x_d, y_q, y_d;
  logic [ACC_W-1:0] acc_q, acc_d;
  logic [IW-1:0]    ipart;
  logic [DIM_W-1:0] r0, r1;

  assign ipart = acc_q[ACC_W-1:FRAC_W];

  always_comb begin
    if (ipart >= {{(IW-DIM_W){1'b0}}, cfg_in_h}) r0 = cfg_in_h - 1'b1;
    else r0 = ipart[DIM_W-1:0];
    if (r0 == cfg_in_h - 1'b1) r1 = r0;
    else r1 = r0 + 1'b1;
  end

  always_comb begin
    st_d = st_q; slot_d = slot_q; line_d = line_q;
    x_d = x_q; y_d = y_q; acc_d = acc_q;
    set_full = '0; fetch_req = 1'b0; in_ready = 1'b0; we = 1'b0;
    if (restart) begin
      st_d = F_IDLE; slot_d = 1'b0; line_d = 1'b0;
      x_d = '0; y_d = '0; acc_d = '0;
    end else begin
      case (st_q)
        F_IDLE: if (run && (y_q < cfg_out_h) && !slot_full[slot_q]) begin
          st_d = F_REQ; line_d = 1'b0;
        end
        F_REQ: begin
          fetch_req = 1'b1; st_d = F_RX; x_d = '0;
        end
        F_RX: begin
          in_ready = 1'b1;
          if (in_valid) begin
            we = 1'b1;
            x_d = x_q + 1'b1;
            if (x_q == cfg_in_w - 1'b1) begin
              if (!line_q) begin
                line_d = 1'b1; st_d = F_REQ;
              end else begin
                set_full[slot_q] = 1'b1;
                slot_d = ~slot_q;
                y_d = y_q + 1'b1;
                acc_d = acc_q + {{DIM_W{1'b0}}, step_y};
                st_d = F_IDLE;
              end
            end
          end
        end
        default: st_d = F_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_l) begin
    if (!rst_l) begin
      st_q <= F_IDLE; slot_q <= 1'b0; line_q <= 1'b0;
      x_q <= '0; y_q <= '0; acc_q <= '0;
    end else begin
      st_q <= st_d; slot_q <= slot_d; line_q <= line_d;
      x_q <= x_d; y_q <= y_d; acc_q <= acc_d;
    end
  end

  assign fetch_row = line_q ? r1 : r0;
  assign waddr     = {slot_q, line_q, x_q[AW-1:0]};
  assign wdata     = in_data;
endmodule

// File: rtl/dsc_lerp.sv
module dsc_lerp
  import dsc_pkg::*;
(
  input  logic [PIX_W-1:0] p00,
  input  logic [PIX_W-1:0] p01,
  input  logic [PIX_W-1:0] p10,
  input  logic [PIX_W-1:0] p11,
  input  logic [WT_W-1:0]  fx,
  input  logic [WT_W-1:0]  fy,
  output logic [PIX_W-1:0] pix
);
  localparam int H_W = PIX_W + WT_W + 1;
  localparam int S_W = H_W + WT_W + 1;

  logic [H_W-1:0] wx0, wx1, wy0, wy1, a, b, c, d, top, bot;
  logic [S_W-1:0] sum, rnd;
  logic [S_W-FRAC_W-1:0] res;

  always_comb begin
    wx1 = {{(H_W-WT_W){1'b0}}, fx};
    wy1 = {{(H_W-WT_W){1'b0}}, fy};
    wx0 = (H_W'(1) << WT_W) - wx1;
    wy0 = (H_W'(1) << WT_W) - wy1;
    a = {{(H_W-PIX_W){1'b0}}, p00};
    b = {{(H_W-PIX_W){1'b0}}, p01};
    c = {{(H_W-PIX_W){1'b0}}, p10};
    d = {{(H_W-PIX_W){1'b0}}, p11};
    top = a * wx0 + b * wx1;
    bot = c * wx0 + d * wx1;
    sum = S_W'(top) * S_W'(wy0) + S_W'(bot) * S_W'(wy1);
    rnd = sum + (S_W'(1) << (FRAC_W - 1));
    res = rnd[S_W-1:FRAC_W];
    if (res > {{(S_W-FRAC_W-PIX_W){1'b0}}, {PIX_W{1'b1}}}) pix = {PIX_W{1'b1}};
    else pix = res[PIX_W-1:0];
  end
endmodule

// File: rtl/dsc_compute.sv
module dsc_compute
  import dsc_pkg::*;
#(
  parameter int DIM_W  = 12,
  parameter int STEP_W = 24,
  parameter int AW     = 6
) (
  input  logic              clk,
  input  logic              rst_l,
  input  logic              restart,
  input  logic              run,
  input  logic [DIM_W-1:0]  cfg_in_w,
  input  logic [DIM_W-1:0]  cfg_out_w,
  input  logic [DIM_W-1:0]  cfg_out_h,
  input  logic [STEP_W-1:0] step_x,
  input  logic [STEP_W-1:0] step_y,
  input  logic [1:0]        in_full,
  input  logic [1:0]        out_full,
  output logic [1:0]        clr_in,
  output logic [1:0]        set_out,
  output logic [AW+1:0]     ra00,
  output logic [AW+1:0]     ra01,
  output logic [AW+1:0]     ra10,
  output logic [AW+1:0]     ra11,
  input  logic [PIX_W-1:0]  rd00,
  input  logic [PIX_W-1:0]  rd01,
  input  logic [PIX_W-1:0]  rd10,
  input  logic [PIX_W-1:0]  rd11,
  output logic              we,
  output logic [AW:0]       waddr,
  output logic [PIX_W-1:0]  wdata
);
  localparam int ACC_W = DIM_W + STEP_W;
  localparam int IW    = ACC_W - FRAC_W;

  comp_st_t st_q, st_d;
  logic rd_q, rd_d, wr_q, wr_d;
  logic [DIM_W-1:0] x_q, x_d, y_q, y_d;
  logic [ACC_W-1:0] sx_q, sx_d, sy_q, sy_d;
  logic [IW-1:0]    ipart;
  logic [DIM_W-1:0] c0, c1;

  assign ipart = sx_q[ACC_W-1:FRAC_W];

  always_comb begin
    if (ipart >= {{(IW-DIM_W){1'b0}}, cfg_in_w}) c0 = cfg_in_w - 1'b1;
    else c0 = ipart[DIM_W-1:0];
    if (c0 == cfg_in_w - 1'b1) c1 = c0;
    else c1 = c0 + 1'b1;
  end

  assign ra00 = {rd_q, 1'b0, c0[AW-1:0]};
  assign ra01 = {rd_q, 1'b0, c1[AW-1:0]};
  assign ra10 = {rd_q, 1'b1, c0[AW-1:0]};
  assign ra11 = {rd_q, 1'b1, c1[AW-1:0]};

  dsc_lerp u_lerp (
    .p00(rd00), .p01(rd01), .p10(rd10), .p11(rd11),
    .fx (sx_q[FRAC_W-1 -: WT_W]),
    .fy (sy_q[FRAC_W-1 -: WT_W]),
    .pix(wdata)
  );

  always_comb begin
    st_d = st_q; rd_d = rd_q; wr_d = wr_q;
    x_d = x_q; y_d = y_q; sx_d = sx_q; sy_d = sy_q;
    clr_in = '0; set_out = '0; we = 1'b0;
    if (restart) begin
      st_d = C_IDLE; rd_d = 1'b0; wr_d = 1'b0;
      x_d = '0; y_d = '0; sx_d = '0; sy_d = '0;
    end else begin
      case (st_q)
        C_IDLE: if (run && (y_q < cfg_out_h) && in_full[rd_q] && !out_full[wr_q]) begin
          st_d = C_RUN; x_d = '0; sx_d = '0;
        end
        C_RUN: begin
          we = 1'b1;
          x_d = x_q + 1'b1;
          sx_d = sx_q + {{DIM_W{1'b0}}, step_x};
          if (x_q == cfg_out_w - 1'b1) begin
            clr_in[rd_q] = 1'b1;
            set_out[wr_q] = 1'b1;
            rd_d = ~rd_q; wr_d = ~wr_q;
            y_d = y_q + 1'b1;
            sy_d = sy_q + {{DIM_W{1'b0}}, step_y};
            st_d = C_IDLE;
          end
        end
        default: st_d = C_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_l) begin
    if (!rst_l) begin
      st_q <= C_IDLE; rd_q <= 1'b0; wr_q <= 1'b0;
      x_q <= '0; y_q <= '0; sx_q <= '0; sy_q <= '0;
    end else begin
      st_q <= st_d; rd_q <= rd_d; wr_q <= wr_d;
      x_q <= x_d; y_q <= y_d; sx_q <= sx_d; sy_q <= sy_d;
    end
  end

  assign waddr = {wr_q, x_q[AW-1:0]};
endmodule

// File: rtl/dsc_drain.sv
module dsc_drain #(
  parameter int DIM_W = 12,
  parameter int AW    = 6
) (
  input  logic             clk,
  input  logic             rst_l,
  input  logic             restart,
  input  logic             run,
  input  logic [DIM_W-1:0] cfg_out_w,
  input  logic [DIM_W-1:0] cfg_out_h,
  input  logic [1:0]       out_full,
  output logic [1:0]       clr_out,
  output logic [AW:0]      raddr,
  output logic             out_valid,
  input  logic             out_ready,
  output logic             frame_done
);
  logic rd_q, rd_d;
  logic [DIM_W-1:0] x_q, x_d, y_q, y_d;
  logic eol;

  assign out_valid  = run && out_full[rd_q];
  assign eol        = (x_q == cfg_out_w - 1'b1);
  assign frame_done = out_valid && eol && (y_q == cfg_out_h - 1'b1);
  assign raddr      = {rd_q, x_q[AW-1:0]};

  always_comb begin
    rd_d = rd_q; x_d = x_q; y_d = y_q; clr_out = '0;
    if (restart) begin
      rd_d = 1'b0; x_d = '0; y_d = '0;
    end else if (out_valid && out_ready) begin
      if (eol) begin
        clr_out[rd_q] = 1'b1;
        rd_d = ~rd_q; x_d = '0; y_d = y_q + 1'b1;
      end else begin
        x_d = x_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_l) begin
    if (!rst_l) begin
      rd_q <= 1'b0; x_q <= '0; y_q <= '0;
    end else begin
      rd_q <= rd_d; x_q <= x_d; y_q <= y_d;
    end
  end
endmodule

// File: rtl/line_downscaler.sv
module line_downscaler
  import dsc_pkg::*;
#(
  parameter int MAX_W  = 64,
  parameter int DIM_W  = 12,
  parameter int STEP_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DIM_W-1:0]  cfg_in_w,
  input  logic [DIM_W-1:0]  cfg_in_h,
  input  logic [DIM_W-1:0]  cfg_out_w,
  input  logic [DIM_W-1:0]  cfg_out_h,
  input  logic [STEP_W-1:0] cfg_step_x,
  input  logic [STEP_W-1:0] cfg_step_y,
  output logic              fetch_req,
  output logic [DIM_W-1:0]  fetch_row,
  input  logic              in_valid,
  input  logic [PIX_W-1:0]  in_data,
  output logic              in_ready,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [PIX_W-1:0]  out_data,
  output logic              frame_done,
  output logic              busy
);
  localparam int AW        = $clog2(MAX_W);
  localparam int IN_DEPTH  = 4 * MAX_W;
  localparam int OUT_DEPTH = 2 * MAX_W;

  logic [1:0] rs_q;
  logic rst_l;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_l = rs_q[1];

  logic start_go, busy_q, busy_d;
  logic [DIM_W-1:0]  w_in_q, h_in_q, w_out_q, h_out_q;
  logic [STEP_W-1:0] sx_q, sy_q;

  assign start_go = start && !busy_q;

  always_ff @(posedge clk or negedge rst_l) begin
    if (!rst_l) begin
      w_in_q <= '0; h_in_q <= '0; w_out_q <= '0; h_out_q <= '0;
      sx_q <= '0; sy_q <= '0;
    end else if (start_go) begin
      w_in_q <= cfg_in_w; h_in_q <= cfg_in_h;
      w_out_q <= cfg_out_w; h_out_q <= cfg_out_h;
      sx_q <= cfg_step_x; sy_q <= cfg_step_y;
    end
  end

  always_comb begin
    busy_d = busy_q;
    if (start_go) busy_d = 1'b1;
    else if (frame_done && out_ready) busy_d = 1'b0;
  end

  logic [1:0] in_full_q, in_full_d, out_full_q, out_full_d;
  logic [1:0] in_set, in_clr, out_set, out_clr;

  always_comb begin
    in_full_d  = (in_full_q | in_set) & ~in_clr;
    out_full_d = (out_full_q | out_set) & ~out_clr;
    if (start_go) begin
      in_full_d = '0; out_full_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_l) begin
    if (!rst_l) begin
      busy_q <= 1'b0; in_full_q <= '0; out_full_q <= '0;
    end else begin
      busy_q <= busy_d; in_full_q <= in_full_d; out_full_q <= out_full_d;
    end
  end
  assign busy = busy_q;

  logic [PIX_W-1:0] in_mem  [IN_DEPTH];
  logic [PIX_W-1:0] out_mem [OUT_DEPTH];
  logic             in_we, out_we;
  logic [AW+1:0]    in_waddr, ra00, ra01, ra10, ra11;
  logic [AW:0]      out_waddr, out_raddr;
  logic [PIX_W-1:0] in_wdata, out_wdata;

  always_ff @(posedge clk) begin
    if (in_we) in_mem[in_waddr] <= in_wdata;
  end
  always_ff @(posedge clk) begin
    if (out_we) out_mem[out_waddr] <= out_wdata;
  end

  dsc_fetch #(.DIM_W(DIM_W), .STEP_W(STEP_W), .AW(AW)) u_fetch (
    .clk(clk), .rst_l(rst_l), .restart(start_go), .run(busy_q),
    .cfg_in_w(w_in_q), .cfg_in_h(h_in_q), .cfg_out_h(h_out_q), .step_y(sy_q),
    .slot_full(in_full_q), .set_full(in_set),
    .fetch_req(fetch_req), .fetch_row(fetch_row),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .we(in_we), .waddr(in_waddr), .wdata(in_wdata)
  );

  dsc_compute #(.DIM_W(DIM_W), .STEP_W(STEP_W), .AW(AW)) u_comp (
    .clk(clk), .rst_l(rst_l), .restart(start_go), .run(busy_q),
    .cfg_in_w(w_in_q), .cfg_out_w(w_out_q), .cfg_out_h(h_out_q),
    .step_x(sx_q), .step_y(sy_q),
    .in_full(in_full_q), .out_full(out_full_q),
    .clr_in(in_clr), .set_out(out_set),
    .ra00(ra00), .ra01(ra01), .ra10(ra10), .ra11(ra11),
    .rd00(in_mem[ra00]), .rd01(in_mem[ra01]),
    .rd10(in_mem[ra10]), .rd11(in_mem[ra11]),
    .we(out_we), .waddr(out_waddr), .wdata(out_wdata)
  );

  dsc_drain #(.DIM_W(DIM_W), .AW(AW)) u_drain (
    .clk(clk), .rst_l(rst_l), .restart(start_go), .run(busy_q),
    .cfg_out_w(w_out_q), .cfg_out_h(h_out_q),
    .out_full(out_full_q), .clr_out(out_clr), .raddr(out_raddr),
    .out_valid(out_valid), .out_ready(out_ready), .frame_done(frame_done)
  );

  assign out_data = out_mem[out_raddr];
endmodule

// File: rtl/dsc_chk.sv
module dsc_chk #(
  parameter int DIM_W = 12
) (
  input logic             clk,
  input logic             rst_l,
  input logic             fetch_req,
  input logic [DIM_W-1:0] fetch_row,
  input logic [DIM_W-1:0] h_in_q,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [7:0]       out_data,
  input logic             frame_done,
  input logic             busy
);
  // R7
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_l)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R3
  row_range_chk: assert property (@(posedge clk) disable iff (!rst_l)
    fetch_req |-> (fetch_row < h_in_q));

  // R3
  ready_after_req_chk: assert property (@(posedge clk) disable iff (!rst_l)
    fetch_req |=> in_ready);

  // R6
  done_with_valid_chk: assert property (@(posedge clk) disable iff (!rst_l)
    frame_done |-> out_valid);

  // R2
  busy_end_chk: assert property (@(posedge clk) disable iff (!rst_l)
    $fell(busy) |-> $past(frame_done && out_ready));

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_l)
    !busy |-> (!out_valid && !fetch_req));
endmodule

bind line_downscaler dsc_chk #(.DIM_W(DIM_W)) u_chk (
  .clk(clk), .rst_l(rst_l), .fetch_req(fetch_req), .fetch_row(fetch_row),
  .h_in_q(h_in_q), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_data(out_data), .frame_done(frame_done),
  .busy(busy)
);

// File: tb/sim_line_downscaler.sv
module sim_line_downscaler;
  logic clk = 1'b0;
  logic rst_n, start;
  logic [11:0] cfg_in_w, cfg_in_h, cfg_out_w, cfg_out_h;
  logic [23:0] cfg_step_x, cfg_step_y;
  logic fetch_req, in_valid, in_ready, out_valid, out_ready, frame_done, busy;
  logic [11:0] fetch_row;
  logic [7:0] in_data, out_data;

  always #4 clk = ~clk;

  line_downscaler u0 (
    .clk(clk), .rst_n(rst_n), .start(start),
    .cfg_in_w(cfg_in_w), .cfg_in_h(cfg_in_h), .cfg_out_w(cfg_out_w), .cfg_out_h(cfg_out_h),
    .cfg_step_x(cfg_step_x), .cfg_step_y(cfg_step_y),
    .fetch_req(fetch_req), .fetch_row(fetch_row),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .frame_done(frame_done), .busy(busy)
  );

  int img [64][64];
  int iw, ih, ow, oh, sx, sy;
  int pix_n, req_n, tests, fails;
  bit hold, finished;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_pix(input int x, input int y);
    longint ax = longint'(x) * sx;
    longint ay = longint'(y) * sy;
    int i0 = int'(ax >> 16), j0 = int'(ay >> 16);
    int i1, j1, fx, fy;
    longint v;
    if (i0 > iw - 1) i0 = iw - 1;
    if (j0 > ih - 1) j0 = ih - 1;
    i1 = (i0 + 1 > iw - 1) ? iw - 1 : i0 + 1;
    j1 = (j0 + 1 > ih - 1) ? ih - 1 : j0 + 1;
    fx = int'((ax >> 8) & 255);
    fy = int'((ay >> 8) & 255);
    v = longint'(img[j0][i0] * (256 - fx) + img[j0][i1] * fx) * (256 - fy)
      + longint'(img[j1][i0] * (256 - fx) + img[j1][i1] * fx) * fy;
    v = (v + 32768) >>> 16;
    if (v > 255) v = 255;
    return int'(v);
  endfunction

  // pixel source
  initial begin
    int row, k;
    in_valid = 1'b0; in_data = 8'd0;
    forever begin
      @(negedge clk);
      in_valid = 1'b0;
      if (fetch_req) begin
        row = int'(fetch_row); k = 0;
        while (k < iw) begin
          @(negedge clk);
          in_valid = ($urandom % 4) != 0;
          in_data = 8'(img[row][k]);
          if (in_valid && in_ready) k++;
        end
      end
    end
  end

  // fetch request monitor (R3)
  initial begin
    int ln, r0, e;
    forever begin
      @(negedge clk);
      if (fetch_req) begin
        ln = req_n / 2;
        r0 = int'((longint'(ln) * sy) >> 16);
        if (r0 > ih - 1) r0 = ih - 1;
        e = (req_n % 2 == 1) ? ((r0 + 1 > ih - 1) ? ih - 1 : r0 + 1) : r0;
        chk(int'(fetch_row) == e, "R3 row", int'(fetch_row), e);
        req_n++;
      end
    end
  end

  // output sink (R4 R5 R6 R7)
  initial begin
    bit prev_stall;
    logic [7:0] prev_data;
    int x, y, e;
    prev_stall = 1'b0; prev_data = 8'd0; out_ready = 1'b0;
    forever begin
      @(negedge clk);
      if (prev_stall) begin
        chk(out_valid == 1'b1, "R7 valid held", int'(out_valid), 1);
        chk(out_data == prev_data, "R7 data held", int'(out_data), int'(prev_data));
      end
      out_ready = hold ? 1'b0 : (($urandom % 4) != 0);
      if (out_valid && out_ready) begin
        y = pix_n / ow; x = pix_n % ow;
        e = exp_pix(x, y);
        chk(int'(out_data) == e, "R4 R5 pixel", int'(out_data), e);
        chk(frame_done == (pix_n == ow * oh - 1), "R6 frame_done", int'(frame_done),
            int'(pix_n == ow * oh - 1));
        pix_n++;
      end
      prev_stall = out_valid && !out_ready;
      prev_data = out_data;
    end
  end

  task automatic run_frame(input int a_iw, input int a_ih, input int a_ow, input int a_oh,
                           input int a_sx, input int a_sy, input bit stall, input bit restart_mid);
    int n;
    iw = a_iw; ih = a_ih; ow = a_ow; oh = a_oh; sx = a_sx; sy = a_sy;
    pix_n = 0; req_n = 0; hold = stall;
    cfg_in_w = 12'(iw); cfg_in_h = 12'(ih); cfg_out_w = 12'(ow); cfg_out_h = 12'(oh);
    cfg_step_x = 24'(sx); cfg_step_y = 24'(sy);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    // R2: scramble configuration after capture
    cfg_in_w = 12'd3; cfg_in_h = 12'd2; cfg_out_w = 12'd2; cfg_out_h = 12'd1;
    cfg_step_x = 24'h030000; cfg_step_y = 24'h020000;
    chk(busy == 1'b1, "R2 busy after start", int'(busy), 1);
    if (stall) begin
      repeat (400) @(negedge clk);
      chk(req_n == 8, "R8 fetches while stalled", req_n, 8);
      chk(pix_n == 0, "R8 nothing drained", pix_n, 0);
      chk(out_valid == 1'b1, "R8 output waiting", int'(out_valid), 1);
      hold = 1'b0;
    end
    if (restart_mid) begin
      repeat (40) @(negedge clk);
      start = 1'b1;
      @(negedge clk); start = 1'b0;
      chk(busy == 1'b1, "R9 start ignored", int'(busy), 1);
    end
    n = 0;
    while (pix_n < ow * oh && n < 20000) begin
      @(negedge clk); n++;
    end
    chk(pix_n == ow * oh, "R6 pixel count", pix_n, ow * oh);
    @(negedge clk);
    chk(busy == 1'b0, "R2 busy cleared", int'(busy), 0);
    chk(req_n == 2 * oh, "R3 request count", req_n, 2 * oh);
    repeat (3) @(negedge clk);
  endtask

  task automatic fill_random;
    for (int r = 0; r < 64; r++)
      for (int c = 0; c < 64; c++) img[r][c] = int'($urandom % 256);
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    summary();
  end

  initial begin
    void'($urandom(32'd1234));
    tests = 0; fails = 0; finished = 1'b0; hold = 1'b0;
    iw = 1; ih = 1; ow = 1; oh = 1; sx = 65536; sy = 65536;
    rst_n = 1'b0; start = 1'b0;
    cfg_in_w = '0; cfg_in_h = '0; cfg_out_w = '0; cfg_out_h = '0;
    cfg_step_x = '0; cfg_step_y = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1
    chk(busy == 1'b0, "R1 busy", int'(busy), 0);
    chk(fetch_req == 1'b0, "R1 fetch_req", int'(fetch_req), 0);
    chk(in_ready == 1'b0, "R1 in_ready", int'(in_ready), 0);
    chk(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);

    fill_random();
    run_frame(8, 6, 8, 6, 32'h10000, 32'h10000, 1'b0, 1'b0);   // R4 unit step
    fill_random();
    run_frame(16, 8, 8, 4, 32'h20000, 32'h20000, 1'b0, 1'b0);  // R4 half size
    fill_random();
    run_frame(13, 7, 9, 5, 32'h19999, 32'h18000, 1'b0, 1'b0);  // R5 edge clamp
    fill_random();
    run_frame(1, 1, 1, 1, 32'h10000, 32'h10000, 1'b0, 1'b0);   // R5 single pixel
    for (int r = 0; r < 64; r++)
      for (int c = 0; c < 64; c++) img[r][c] = 255;
    run_frame(64, 4, 40, 3, 32'h19999, 32'h15555, 1'b0, 1'b0); // R4 saturation
    fill_random();
    run_frame(12, 12, 6, 6, 32'h20000, 32'h20000, 1'b1, 1'b0); // R8 stall
    fill_random();
    run_frame(20, 10, 10, 5, 32'h20000, 32'h20000, 1'b0, 1'b1); // R9 restart ignored
    for (int t = 0; t < 5; t++) begin
      int a, b, c, d;
      fill_random();
      a = 2 + int'($urandom % 63);
      b = 2 + int'($urandom % 15);
      c = 1 + int'($urandom % a);
      d = 1 + int'($urandom % b);
      run_frame(a, b, c, d, (a << 16) / c, (b << 16) / d, 1'b0, 1'b0);
    end
    summary();
  end
endmodule